// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mirrored Masks

This block gathers a set of maskable interrupt sources (external request pins and internal sources such as timers, DMA channels and a serial port) and one nonmaskable input. It decides which request goes to the processor and presents one request at a time with a vector. The processor answers with a one-cycle acknowledge. Each maskable source has a control register that holds a priority field and a mask bit. One global mask register holds the same mask bits, so software can change a single source or all of them.

An acknowledged maskable source enters the in-service state and stays there until software writes its index to the end-of-interrupt register. While a source is in service, a nesting option decides whether a more urgent request may preempt it. The request and vector outputs are registered. They are computed from the state that is being loaded on the same clock edge, so a mask change and the output it affects move together.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset, `int_req` is 0, every mask bit is 1 (global mask reads all ones), every priority field is 7 and nesting is off (config reads 0).
- R2: A maskable source becomes pending on a rising edge of its `irq_in` bit. A level held high produces only one pending request. The pending set reads back at address NSRC+3.
- R3: The control register of source i sits at address i, with priority in bits [2:0] and mask in bit 3. A write sets both fields, and a read returns {mask, priority} zero-extended.
- R4: The global mask register at address NSRC holds mask bit i in bit i. Writing it changes every mask bit on one clock edge. A control-register write of bit 3 and a global write each show up in reads of the other location.
- R5: A masked source is never presented, even while it is pending. Clearing its mask presents it if nothing else blocks it.
- R6: Among eligible maskable sources, the smallest priority value wins, and on equal priority the lower index wins.
- R7: `int_req`/`int_vec` reflect a register write or a request edge sampled at edge t right after edge t. After a mask write, the newly masked source is not presented in any later cycle.
- R8: `int_ack` while a maskable vector is presented clears that source's pending bit and sets its in-service bit. The in-service set reads back at address NSRC+4.
- R9: With nesting off (config bit 0 = 0), no maskable source is presented while any in-service bit is set. A write of index k to address NSRC+1 clears in-service bit k.
- R10: With nesting on, a maskable source is presented only if its priority value is strictly smaller than the smallest priority value among the in-service sources.
- R11: A rising edge on `nmi_in` makes the nonmaskable request pending. It is presented with vector NSRC ahead of all maskable sources, regardless of masks and in-service state. Its acknowledge clears it without setting any in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Maskable request inputs, rising-edge sensitive |
| nmi_in | input | 1 | Nonmaskable request input, rising-edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data, valid the cycle after `reg_rd` |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | VW | Vector of the presented request (NSRC for nonmaskable) |
| int_ack | input | 1 | Acknowledge of the presented request |

## Verification
The hardest state to reach from the ports is a stack of in-service sources under nesting, together with a request of exactly equal priority that must stay blocked. Reaching it takes a fixed order of unmasking, request edges, acknowledges and end-of-interrupt writes. Directed sequences build this state on purpose and then retire the sources out of order. A second delicate case is a global mask write landing on the same edge as a request that was about to be presented; directed steps cover it. A long random run mixes request pulses, acknowledges, writes to every register and nonmaskable edges. A bench model checks every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_MASK, SEL_EOI, SEL_CFG, SEL_PEND, SEL_ISV, SEL_NONE
  } reg_sel_e;

  // Address map: control registers 0..n-1, then global mask, EOI,
  // config, pending status, in-service status.
  function automatic reg_sel_e decode_addr(input int a, input int n);
    if (a < n)          return SEL_CTRL;
    else if (a == n)    return SEL_MASK;
    else if (a == n + 1) return SEL_EOI;
    else if (a == n + 2) return SEL_CFG;
    else if (a == n + 3) return SEL_PEND;
    else if (a == n + 4) return SEL_ISV;
    else                return SEL_NONE;
  endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int PRI_W = 3,
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int IW    = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output logic [NSRC-1:0]             mask_q,
  output logic [NSRC-1:0]             mask_nx,
  output logic [NSRC-1:0][PRI_W-1:0]  prio_q,
  output logic [NSRC-1:0][PRI_W-1:0]  prio_nx,
  output logic                        nest_q,
  output logic                        nest_nx,
  output logic                        eoi_wr,
  output logic [IW-1:0]               eoi_idx
);

  reg_sel_e      sel;
  logic [IW-1:0] idx;
  logic          unused_wdata;

  assign sel          = decode_addr(int'(addr), NSRC);
  assign idx          = addr[IW-1:0];
  assign eoi_wr       = wr && (sel == SEL_EOI);
  assign eoi_idx      = wdata[IW-1:0];
  assign unused_wdata = ^wdata;

  // Single storage for each mask bit: both views read and write it,
  // so the global write lands on all bits in one edge.
  always_comb begin
    mask_nx = mask_q;
    prio_nx = prio_q;
    nest_nx = nest_q;
    if (wr) begin
      case (sel)
        SEL_CTRL: begin
          mask_nx[idx] = wdata[PRI_W];
          prio_nx[idx] = wdata[PRI_W-1:0];
        end
        SEL_MASK: mask_nx = wdata[NSRC-1:0];
        SEL_CFG:  nest_nx = wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      prio_q <= '1;
      nest_q <= 1'b0;
    end else begin
      mask_q <= mask_nx;
      prio_q <= prio_nx;
      nest_q <= nest_nx;
    end
  end

  assert_global_mask_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_MASK) |=> mask_q == $past(wdata[NSRC-1:0]));

  assert_ctrl_mask_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_CTRL) |=> mask_q[$past(idx)] == $past(wdata[PRI_W]));

endmodule

// File: rtl/intc_track.sv
module intc_track #(
  parameter int NSRC = 8,
  parameter int IW   = $clog2(NSRC),
  parameter int VW   = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_in,
  input  logic            nmi_in,
  input  logic            ack,
  input  logic [VW-1:0]   ack_vec,
  input  logic            eoi_wr,
  input  logic [IW-1:0]   eoi_idx,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] pend_nx,
  output logic [NSRC-1:0] isv_q,
  output logic [NSRC-1:0] isv_nx,
  output logic            nmi_q,
  output logic            nmi_nx
);

  localparam logic [VW-1:0] NMI_VEC = VW'(NSRC);

  logic [NSRC-1:0] irq_d, rise, ack_bit, eoi_bit;
  logic            nmi_d, ack_m, ack_n;

  assign rise    = irq_in & ~irq_d;
  assign ack_m   = ack && (ack_vec != NMI_VEC);
  assign ack_n   = ack && (ack_vec == NMI_VEC);
  assign ack_bit = ack_m ? (NSRC'(1) << ack_vec) : '0;
  assign eoi_bit = eoi_wr ? (NSRC'(1) << eoi_idx) : '0;

  assign pend_nx = (pend_q & ~ack_bit) | rise;
  assign isv_nx  = (isv_q & ~eoi_bit) | ack_bit;
  assign nmi_nx  = (nmi_q & ~ack_n) | (nmi_in & ~nmi_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d  <= '0;
      nmi_d  <= 1'b0;
      pend_q <= '0;
      isv_q  <= '0;
      nmi_q  <= 1'b0;
    end else begin
      irq_d  <= irq_in;
      nmi_d  <= nmi_in;
      pend_q <= pend_nx;
      isv_q  <= isv_nx;
      nmi_q  <= nmi_nx;
    end
  end

  assert_ack_sets_service_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_m && !(eoi_wr && eoi_idx == ack_vec[IW-1:0])) |=> isv_q[$past(ack_vec[IW-1:0])]);

  assert_nmi_edge_latched_R11: assert property (@(posedge clk) disable iff (rst)
    (nmi_in && !nmi_d) |=> nmi_q);

endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NSRC  = 8,
  parameter int PRI_W = 3,
  parameter int VW    = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0]            mask,
  input  logic [NSRC-1:0]            isv,
  input  logic [NSRC-1:0][PRI_W-1:0] prio,
  input  logic                       nest,
  input  logic                       nmi,
  output logic                       valid,
  output logic [VW-1:0]              vec
);

  logic             is_any, found;
  logic [PRI_W-1:0] is_min, best_p;
  logic [VW-1:0]    best_i;
  logic [NSRC-1:0]  elig;

  always_comb begin
    is_any = 1'b0;
    is_min = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (isv[i] && (!is_any || prio[i] < is_min)) begin
        is_any = 1'b1;
        is_min = prio[i];
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = pend[g] && !mask[g] &&
                     (!is_any || (nest && prio[g] < is_min));
  end

  // Strict compare keeps the lower index on equal priority.
  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || prio[i] < best_p)) begin
        found  = 1'b1;
        best_p = prio[i];
        best_i = VW'(i);
      end
    end
    valid = nmi || found;
    vec   = nmi ? VW'(NSRC) : best_i;
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int PRI_W = 3,
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int IW    = $clog2(NSRC),
  parameter int VW    = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_in,
  input  logic            nmi_in,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            int_req,
  output logic [VW-1:0]   int_vec,
  input  logic            int_ack
);

  localparam logic [VW-1:0] NMI_VEC = VW'(NSRC);

  logic [NSRC-1:0]            mask_q, mask_nx, pend_q, pend_nx, isv_q, isv_nx;
  logic [NSRC-1:0][PRI_W-1:0] prio_q, prio_nx;
  logic                       nest_q, nest_nx, eoi_wr, nmi_q, nmi_nx, cand_v;
  logic [IW-1:0]              eoi_idx, ridx;
  logic [VW-1:0]              cand_vec;

  intc_regs #(.NSRC(NSRC), .PRI_W(PRI_W), .AW(AW), .DW(DW), .IW(IW)) u_regs (
    .clk, .rst, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mask_q, .mask_nx, .prio_q, .prio_nx, .nest_q, .nest_nx, .eoi_wr, .eoi_idx
  );

  intc_track #(.NSRC(NSRC), .IW(IW), .VW(VW)) u_track (
    .clk, .rst, .irq_in, .nmi_in, .ack(int_ack), .ack_vec(int_vec),
    .eoi_wr, .eoi_idx, .pend_q, .pend_nx, .isv_q, .isv_nx, .nmi_q, .nmi_nx
  );

  // Resolve on the next state so outputs move on the same edge as it.
  intc_pick #(.NSRC(NSRC), .PRI_W(PRI_W), .VW(VW)) u_pick (
    .pend(pend_nx), .mask(mask_nx), .isv(isv_nx), .prio(prio_nx),
    .nest(nest_nx), .nmi(nmi_nx), .valid(cand_v), .vec(cand_vec)
  );

  assign ridx = reg_addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req   <= 1'b0;
      int_vec   <= '0;
      reg_rdata <= '0;
    end else begin
      int_req <= cand_v;
      int_vec <= cand_v ? cand_vec : '0;
      if (reg_rd) begin
        case (decode_addr(int'(reg_addr), NSRC))
          SEL_CTRL: reg_rdata <= DW'({mask_q[ridx], prio_q[ridx]});
          SEL_MASK: reg_rdata <= DW'(mask_q);
          SEL_CFG:  reg_rdata <= DW'(nest_q);
          SEL_PEND: reg_rdata <= DW'(pend_q);
          SEL_ISV:  reg_rdata <= DW'(isv_q);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_nmi_presented_R11: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> (int_req && int_vec == NMI_VEC));

  assert_no_masked_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_vec != NMI_VEC) |-> !mask_q[int_vec[IW-1:0]]);

  assert_no_nest_block_R9: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_vec != NMI_VEC && !nest_q) |-> (isv_q == '0));

  assert_request_pending_R2: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_vec != NMI_VEC) |-> pend_q[int_vec[IW-1:0]]);

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int N = 8, PW = 3, AW = 4, DW = 16, VW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, nmi_in, reg_wr, reg_rd, int_req, int_ack;
  logic [N-1:0]  irq_in;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [VW-1:0] int_vec;

  prio_intc #(.NSRC(N), .PRI_W(PW), .AW(AW), .DW(DW)) uut (
    .clk, .rst, .irq_in, .nmi_in, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .int_req, .int_vec, .int_ack
  );

  // Reference state built from the requirements.
  logic [N-1:0]  m_pend, m_isv, m_mask, m_irq_d;
  logic [PW-1:0] m_prio [N];
  logic          m_nest, m_nmi, m_nmi_d, e_req;
  logic [VW-1:0] e_vec;
  logic [N-1:0]  cur_irq;
  logic          cur_nmi;
  int            total = 0, fails = 0;
  string         phase = "R1 reset";

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", phase, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    if (a < N)           return DW'({m_mask[a[2:0]], m_prio[a[2:0]]});
    else if (a == N)     return DW'(m_mask);
    else if (a == N + 2) return DW'(m_nest);
    else if (a == N + 3) return DW'(m_pend);
    else if (a == N + 4) return DW'(m_isv);
    return '0;
  endfunction

  task automatic pick_model(output logic v, output logic [VW-1:0] vec);
    logic any = 0, fnd = 0;
    logic [PW-1:0] mn = '1, bp = '1;
    v = 0; vec = '0;
    if (m_nmi) begin v = 1; vec = VW'(N); return; end
    for (int i = 0; i < N; i++)
      if (m_isv[i] && (!any || m_prio[i] < mn)) begin any = 1; mn = m_prio[i]; end
    for (int i = 0; i < N; i++)
      if (m_pend[i] && !m_mask[i] && (!any || (m_nest && m_prio[i] < mn)) &&
          (!fnd || m_prio[i] < bp)) begin
        fnd = 1; bp = m_prio[i]; vec = VW'(i);
      end
    v = fnd;
  endtask

  task automatic cyc(input logic [N-1:0] irq, input logic nmi, input logic wr, input logic rd,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ack);
    logic [DW-1:0] er;
    logic [N-1:0]  rise, setb, eclr;
    logic          ackn;
    irq_in = irq; nmi_in = nmi; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = d; int_ack = ack;
    er = rd_model(a);
    @(posedge clk);
    rise = irq & ~m_irq_d; m_irq_d = irq;
    setb = '0; ackn = 0;
    if (ack && e_req) begin
      if (e_vec == VW'(N)) ackn = 1; else setb = N'(1) << e_vec;
    end
    m_nmi = (m_nmi & ~ackn) | (nmi & ~m_nmi_d); m_nmi_d = nmi;
    eclr = (wr && a == N + 1) ? (N'(1) << d[2:0]) : '0;
    m_pend = (m_pend & ~setb) | rise;
    m_isv  = (m_isv & ~eclr) | setb;
    if (wr) begin
      if (a < N) begin m_mask[a[2:0]] = d[PW]; m_prio[a[2:0]] = d[PW-1:0]; end
      else if (a == N) m_mask = d[N-1:0];
      else if (a == N + 2) m_nest = d[0];
    end
    pick_model(e_req, e_vec);
    @(negedge clk);
    chk(int_req == e_req && (!e_req || int_vec == e_vec), "req/vec",
        {int_req, int_req ? int_vec : 4'h0}, {e_req, e_req ? e_vec : 4'h0});
    if (rd) chk(reg_rdata == er, "rdata", reg_rdata, er);
    cur_irq = irq; cur_nmi = nmi;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(cur_irq, cur_nmi, 0, 0, '0, '0, 0);
  endtask
  task automatic wrr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(cur_irq, cur_nmi, 1, 0, a, d, 0);
  endtask
  task automatic rdr(input logic [AW-1:0] a);
    cyc(cur_irq, cur_nmi, 0, 1, a, '0, 0);
  endtask
  task automatic irqs(input logic [N-1:0] v);
    cyc(v, cur_nmi, 0, 0, '0, '0, 0);
  endtask
  task automatic ackc();
    cyc(cur_irq, cur_nmi, 0, 0, '0, '0, e_req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    rst = 1; irq_in = '0; nmi_in = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = '0; reg_wdata = '0; int_ack = 0;
    m_pend = '0; m_isv = '0; m_mask = '1; m_irq_d = '0; m_nest = 0;
    m_nmi = 0; m_nmi_d = 0; e_req = 0; e_vec = '0; cur_irq = '0; cur_nmi = 0;
    for (int i = 0; i < N; i++) m_prio[i] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    phase = "R1 reset";
    chk(int_req == 0, "int_req", int_req, 0);
    rdr(N); rdr(0); rdr(N + 2);

    phase = "R3 R4 mirror";
    wrr(3, 16'h0002); rdr(3); rdr(N);
    wrr(N, 16'h0000); rdr(5); rdr(3);
    wrr(N, 16'h00FF); rdr(3);

    phase = "R2 R5 masked pending";
    irqs(8'h02); idle(3); rdr(N + 3); irqs(8'h00); irqs(8'h02); rdr(N + 3); irqs(8'h00);

    phase = "R5 R7 unmask";
    wrr(1, 16'h0005); idle(1);
    phase = "R7 global mask drop";
    wrr(N, 16'h00FF); idle(2); wrr(1, 16'h0005);

    phase = "R8 acknowledge";
    ackc(); rdr(N + 4); rdr(N + 3);

    phase = "R9 no nesting";
    wrr(0, 16'h0001); irqs(8'h01); irqs(8'h00); idle(2);
    wrr(N + 1, 16'h0001); idle(1); ackc();

    phase = "R10 nesting";
    wrr(N + 2, 16'h0001); rdr(N + 2);
    wrr(2, 16'h0000); irqs(8'h04); irqs(8'h00); ackc();
    wrr(4, 16'h0001); irqs(8'h10); irqs(8'h00); idle(1);
    wrr(N + 1, 16'h0002); idle(1);
    wrr(N + 1, 16'h0000); idle(1); ackc(); rdr(N + 4);
    wrr(N + 1, 16'h0004); wrr(N + 2, 16'h0000);

    phase = "R6 priority order";
    wrr(5, 16'h0003); wrr(6, 16'h0003); wrr(7, 16'h0002);
    irqs(8'he0); irqs(8'h00);
    ackc(); wrr(N + 1, 16'h0007);
    ackc(); wrr(N + 1, 16'h0005);
    ackc(); wrr(N + 1, 16'h0006); idle(1);

    phase = "R11 nonmaskable";
    irqs(8'h20); ackc(); wrr(N, 16'h00FF);
    cyc(cur_irq, 1, 0, 0, '0, '0, 0); idle(3); ackc(); idle(2);
    cyc(cur_irq, 0, 0, 0, '0, '0, 0); rdr(N + 4);
    wrr(N + 1, 16'h0005); irqs(8'h00);

    phase = "R5 R6 R8 R10 random";
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0]  v;
      logic          w, r, nm;
      logic [AW-1:0] a;
      v  = N'($urandom & $urandom & $urandom);
      nm = ($urandom % 64) == 0;
      w  = 0; r = 0; a = '0;
      case ($urandom % 6)
        0: begin w = 1; a = AW'($urandom % (N + 3)); end
        1: begin r = 1; a = AW'($urandom % 16); end
        default: ;
      endcase
      cyc(v, nm, w, r, a, DW'($urandom), e_req && ($urandom % 2 == 0));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule